// File: doc/BRIEF.md
# GPIO Port Controller with Pin Interrupts

This block controls one port of up to eight general-purpose pins behind a small word-addressed register bus. Every pin owns a 32-byte window of registers: configuration, a debounce threshold, the sampled input, an output float control, the output level and an interrupt clear. The block drives each pad's output level and output enable. It brings the pad inputs into the clock domain through a two-flop synchroniser and can pass them through a per-pin debounce filter. The filter counts an external 1 ms tick.

Each pin can raise an interrupt on a level, a single edge or both edges. A 2-bit trigger kind and a separate polarity bit select the condition. Events are latched into a per-port pending register, one bit per pin. The single interrupt output is the OR of the pending bits. Software acknowledges a pin by writing its clear register. Reads are combinational from `bus_addr_i`. A write takes effect on the clock edge where `bus_we_i` is high. Address bits [1:0] are ignored.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset every pin reads configuration 0, threshold 0, output control 1 (floated) and output value 0. The pending register reads 0, `irq_o` is 0 and every `pad_oe_o` bit is 0.
- R2: Pin n's registers sit at n×0x20: configuration at +0x00 (7 bits), threshold at +0x04 (8 bits), input at +0x08, output control at +0x0C (bit 0), output value at +0x10 (bit 0) and interrupt clear at +0x14. Bits not implemented read 0, and the clear register always reads 0.
- R3: Configuration bit 0 enables the pin and bit 1 selects output. `pad_oe_o[n]` is high exactly when the pin is enabled, set as output and not floated. `pad_out_o[n]` carries output-value bit 0.
- R4: Input bit 0 reads the pad level after two synchroniser flops and the filter stage. With debounce off (configuration bit 5 = 0) or a threshold of 0, a pad change is visible within three clock cycles.
- R5: With configuration bit 5 set and a threshold N > 0, the filtered level changes only after the synchronised pad has differed from it across N tick pulses with no return in between. A return to the filtered level restarts the count.
- R6: Trigger kind is configuration bits [3:2] and polarity is bit 4. Kind 2 latches a rising edge when polarity = 1 and a falling edge when polarity = 0. Kind 3 latches both edges. An edge-latched bit stays set until it is cleared.
- R7: Kind 1 is a level trigger: active-high when polarity = 1 and active-low when polarity = 0. The pending bit is set again on every cycle the active level is present, so a clear has no lasting effect until the level goes inactive.
- R8: A pin latches nothing when it is disabled (bit 0 = 0), when its kind is 0, or when its interrupt enable (bit 6) is 0.
- R9: Writing a word with bit 0 = 1 to a pin's clear register clears its pending bit. A word with bit 0 = 0 has no effect. An event in the same cycle as the clear leaves the bit set.
- R10: The pending register at 0x104 shows pin n at bit n, reads 0 above bit 7, and ignores writes. `irq_o` is high when any pending bit is set.
- R11: Undefined offsets (+0x18 and +0x1C in a pin window, windows of pins not present, and 0x100 to 0x1FF except 0x104) read 0, and writes to them change nothing. Writes to the input register change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_ms_i | input | 1 | One-cycle pulse every millisecond for the debounce count |
| bus_we_i | input | 1 | Write strobe |
| bus_addr_i | input | 9 | Byte address inside the port window |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| pad_in_i | input | 8 | Raw pad levels, asynchronous |
| pad_out_o | output | 8 | Output levels to the pads |
| pad_oe_o | output | 8 | Output driver enables to the pads |
| irq_o | output | 1 | Port interrupt, OR of the pending bits |

## Verification
A new trigger event and a software clear can hit the same pin's pending bit in the same clock cycle. The bench provokes this by changing a pad with the pin set for both edges. It then times the clear write so that the write is sampled on the exact edge where the synchronised transition reaches the detector, three clocks after the pad change. The pending bit must read 1 afterwards, because the event takes priority. The same sequence with the clear one cycle later must leave the bit at 0, which shows the priority came from the overlap and not from a clear that does nothing.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [1:0] {
    TRIG_NONE  = 2'd0,
    TRIG_LEVEL = 2'd1,
    TRIG_EDGE  = 2'd2,
    TRIG_BOTH  = 2'd3
  } trig_e;

  // bit0 en, bit1 dir_out, [3:2] trig, bit4 pol, bit5 db_en, bit6 irq_en
  typedef struct packed {
    logic  irq_en;
    logic  db_en;
    logic  pol;
    trig_e trig;
    logic  dir_out;
    logic  en;
  } pin_cfg_t;

  localparam logic [2:0] R_CFG  = 3'd0;
  localparam logic [2:0] R_DB   = 3'd1;
  localparam logic [2:0] R_IN   = 3'd2;
  localparam logic [2:0] R_OCTL = 3'd3;
  localparam logic [2:0] R_OVAL = 3'd4;
  localparam logic [2:0] R_ICLR = 3'd5;

  localparam int STATUS_OFFSET = 'h104;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/gpio_debounce.sv
module gpio_debounce #(
  parameter int THR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic [THR_W-1:0] thr_i,
  input  logic             raw_i,
  output logic             level_o
);

  logic             lvl_q;
  logic [THR_W-1:0] cnt_q;
  logic [THR_W:0]   cnt_nxt;
  logic             bypass;

  assign bypass  = !en_i || (thr_i == '0);
  assign cnt_nxt = {1'b0, cnt_q} + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
      cnt_q <= '0;
    end else if (bypass) begin
      lvl_q <= raw_i;
      cnt_q <= '0;
    end else if (raw_i == lvl_q) begin
      cnt_q <= '0;  // bounce back restarts the hold window
    end else if (tick_i) begin
      if (cnt_nxt >= {1'b0, thr_i}) begin
        lvl_q <= raw_i;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_nxt[THR_W-1:0];
      end
    end
  end

  assign level_o = lvl_q;

endmodule

// File: rtl/gpio_evt_det.sv
module gpio_evt_det
  import gpio_port_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  level_i,
  input  logic  armed_i,
  input  trig_e trig_i,
  input  logic  pol_i,
  output logic  evt_o
);

  logic prev_q;
  logic rise, fall, hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= level_i;
  end

  assign rise = level_i & ~prev_q;
  assign fall = ~level_i & prev_q;

  always_comb begin
    unique case (trig_i)
      TRIG_LEVEL: hit = (level_i == pol_i);
      TRIG_EDGE:  hit = pol_i ? rise : fall;
      TRIG_BOTH:  hit = rise | fall;
      default:    hit = 1'b0;
    endcase
  end

  assign evt_o = armed_i & hit;

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int DB_W        = 8,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 9,
  parameter int DATA_W      = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_ms_i,
  input  logic                bus_we_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [DATA_W-1:0]   bus_wdata_i,
  output logic [DATA_W-1:0]   bus_rdata_o,
  input  logic [NUM_PINS-1:0] pad_in_i,
  output logic [NUM_PINS-1:0] pad_out_o,
  output logic [NUM_PINS-1:0] pad_oe_o,
  output logic                irq_o
);

  localparam int PIN_SEL_W = 3;
  localparam int CFG_W     = $bits(pin_cfg_t);
  localparam logic [ADDR_W-3:0] STAT_WORD = (ADDR_W-2)'(STATUS_OFFSET >> 2);

  // decode
  logic                 pin_space, pin_hit, stat_hit, wr_pin;
  logic [PIN_SEL_W-1:0] pin_sel;
  logic [2:0]           reg_sel;

  assign pin_space = (bus_addr_i[ADDR_W-1:8] == '0);
  assign pin_sel   = bus_addr_i[7:5];
  assign reg_sel   = bus_addr_i[4:2];
  assign pin_hit   = pin_space && (int'(pin_sel) < NUM_PINS);
  assign stat_hit  = (bus_addr_i[ADDR_W-1:2] == STAT_WORD);
  assign wr_pin    = bus_we_i && pin_hit;

  // per-pin registers
  pin_cfg_t            cfg_q   [NUM_PINS];
  logic [DB_W-1:0]     thr_q   [NUM_PINS];
  logic [NUM_PINS-1:0] float_q;
  logic [NUM_PINS-1:0] oval_q;
  logic [NUM_PINS-1:0] status_q;
  logic [NUM_PINS-1:0] clr;
  logic [NUM_PINS-1:0] evt;
  logic [NUM_PINS-1:0] armed;
  logic [NUM_PINS-1:0] pad_sync;
  logic [NUM_PINS-1:0] pin_lvl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int p = 0; p < NUM_PINS; p++) begin
        cfg_q[p] <= '0;
        thr_q[p] <= '0;
      end
      float_q <= '1;
      oval_q  <= '0;
    end else if (wr_pin) begin
      for (int p = 0; p < NUM_PINS; p++) begin
        if (pin_sel == PIN_SEL_W'(p)) begin
          case (reg_sel)
            R_CFG:   cfg_q[p]   <= pin_cfg_t'(bus_wdata_i[CFG_W-1:0]);
            R_DB:    thr_q[p]   <= bus_wdata_i[DB_W-1:0];
            R_OCTL:  float_q[p] <= bus_wdata_i[0];
            R_OVAL:  oval_q[p]  <= bus_wdata_i[0];
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    for (int p = 0; p < NUM_PINS; p++) begin
      clr[p] = wr_pin && (pin_sel == PIN_SEL_W'(p)) && (reg_sel == R_ICLR) && bus_wdata_i[0];
    end
  end

  // input path
  gpio_sync #(
    .W      (NUM_PINS),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pad_in_i),
    .q_o    (pad_sync)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    gpio_debounce #(
      .THR_W (DB_W)
    ) u_db (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (tick_ms_i),
      .en_i    (cfg_q[p].db_en),
      .thr_i   (thr_q[p]),
      .raw_i   (pad_sync[p]),
      .level_o (pin_lvl[p])
    );

    assign armed[p] = cfg_q[p].en & cfg_q[p].irq_en & (cfg_q[p].trig != TRIG_NONE);

    gpio_evt_det u_evt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .level_i (pin_lvl[p]),
      .armed_i (armed[p]),
      .trig_i  (cfg_q[p].trig),
      .pol_i   (cfg_q[p].pol),
      .evt_o   (evt[p])
    );

    assign pad_oe_o[p] = cfg_q[p].en & cfg_q[p].dir_out & ~float_q[p];
  end

  assign pad_out_o = oval_q;

  // pending: set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= evt | (status_q & ~clr);
  end

  assign irq_o = |status_q;

  // read mux
  always_comb begin
    bus_rdata_o = '0;
    if (stat_hit) begin
      bus_rdata_o[NUM_PINS-1:0] = status_q;
    end else if (pin_hit) begin
      case (reg_sel)
        R_CFG:   bus_rdata_o[CFG_W-1:0] = cfg_q[pin_sel];
        R_DB:    bus_rdata_o[DB_W-1:0]  = thr_q[pin_sel];
        R_IN:    bus_rdata_o[0]         = pin_lvl[pin_sel];
        R_OCTL:  bus_rdata_o[0]         = float_q[pin_sel];
        R_OVAL:  bus_rdata_o[0]         = oval_q[pin_sel];
        default: ;
      endcase
    end
  end

  logic unused_bits;
  assign unused_bits = ^{bus_wdata_i[DATA_W-1:DB_W], bus_addr_i[1:0]};

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int NUM_PINS = 8,
  parameter int ADDR_W   = 9,
  parameter int DATA_W   = 32
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                bus_we_i,
  input logic [ADDR_W-1:0]   bus_addr_i,
  input logic [DATA_W-1:0]   bus_wdata_i,
  input logic [NUM_PINS-1:0] pad_oe_o,
  input logic [NUM_PINS-1:0] pad_out_o,
  input logic [NUM_PINS-1:0] status_i,
  input logic [NUM_PINS-1:0] evt_i
);

  logic                wr_in_pins;
  logic                wr_undef;
  logic [NUM_PINS-1:0] wr_clr1;
  logic [NUM_PINS-1:0] wr_float1;

  always_comb begin
    wr_in_pins = bus_we_i && (bus_addr_i[ADDR_W-1:8] == '0)
                 && (int'(bus_addr_i[7:5]) < NUM_PINS) && (bus_addr_i[4:2] < 3'd6);
    wr_undef   = bus_we_i && !wr_in_pins;
    for (int k = 0; k < NUM_PINS; k++) begin
      wr_clr1[k]   = wr_in_pins && (int'(bus_addr_i[7:5]) == k)
                     && (bus_addr_i[4:2] == 3'd5) && bus_wdata_i[0];
      wr_float1[k] = wr_in_pins && (int'(bus_addr_i[7:5]) == k)
                     && (bus_addr_i[4:2] == 3'd3) && bus_wdata_i[0];
    end
  end

  for (genvar k = 0; k < NUM_PINS; k++) begin : g_k
    p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_clr1[k] && !evt_i[k] |=> !status_i[k]);

    p_event_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[k] |=> status_i[k]);

    p_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      status_i[k] && !wr_clr1[k] |=> status_i[k]);

    p_float_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_float1[k] |=> !pad_oe_o[k]);
  end

  p_undef_write_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_undef |=> $stable(pad_oe_o) && $stable(pad_out_o));

endmodule

bind gpio_port_ctrl gpio_port_chk #(
  .NUM_PINS (NUM_PINS),
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .pad_oe_o    (pad_oe_o),
  .pad_out_o   (pad_out_o),
  .status_i    (status_q),
  .evt_i       (evt)
);

// File: tb/sim_gpio_port_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_port_ctrl;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        we = 1'b0;
  logic [8:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [N-1:0] pad = '0;
  logic [N-1:0] pout, poe;
  logic        irq;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  gpio_port_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_ms_i(tick), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .pad_in_i(pad), .pad_out_o(pout), .pad_oe_o(poe), .irq_o(irq)
  );

  function automatic logic [8:0] pa(input int p, input int r);
    return 9'(p * 32 + r * 4);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk); we = 1'b0; addr = a; #1; d = rdata;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  initial begin
    #1_000_000;
    n_err++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [N-1:0] v;
    cyc(3); rst_n = 1'b1; cyc(1);

    // R1 reset state
    check("R1 oe", 32'(poe), 0);
    check("R1 irq", 32'(irq), 0);
    for (int p = 0; p < N; p++) begin
      rd(pa(p, 0), d); check("R1 cfg", d, 0);
      rd(pa(p, 1), d); check("R1 thr", d, 0);
      rd(pa(p, 3), d); check("R1 float", d, 1);
      rd(pa(p, 4), d); check("R1 oval", d, 0);
    end
    rd(9'h104, d); check("R1 status", d, 0);

    // R2 field widths and readback
    for (int p = 0; p < N; p++) begin
      wr(pa(p, 1), 32'hFFFF_FFFF); rd(pa(p, 1), d); check("R2 thr", d, 32'hFF);
      wr(pa(p, 4), 32'hFFFF_FFFE); rd(pa(p, 4), d); check("R2 oval", d, 0);
      wr(pa(p, 5), 32'hFFFF_FFFF); rd(pa(p, 5), d); check("R2 clr reads 0", d, 0);
      wr(pa(p, 1), 0);
    end
    wr(pa(3, 0), 32'hFFFF_FF80); rd(pa(3, 0), d); check("R2 cfg", d, 0);
    wr(pa(3, 0), 32'h0000_0023); rd(pa(3, 0), d); check("R2 cfg", d, 32'h23);
    wr(pa(3, 0), 0);

    // R3 drive sweep
    for (int p = 0; p < N; p++) begin
      for (int c = 0; c < 16; c++) begin
        wr(pa(p, 0), 32'(c & 3));
        wr(pa(p, 3), 32'((c >> 2) & 1));
        wr(pa(p, 4), 32'((c >> 3) & 1));
        cyc(1);
        check("R3 oe", 32'(poe), 32'(((c & 3) == 3 && ((c >> 2) & 1) == 0) ? (1 << p) : 0));
        check("R3 out", 32'(pout[p]), 32'((c >> 3) & 1));
      end
      wr(pa(p, 0), 0); wr(pa(p, 3), 1); wr(pa(p, 4), 0);
    end

    // R4 input sweep, no debounce
    for (int x = 0; x < 256; x++) begin
      @(negedge clk); pad = 8'(x);
      cyc(3);
      v = '0;
      for (int p = 0; p < N; p++) begin
        rd(pa(p, 2), d); v[p] = d[0];
      end
      check("R4 input", 32'(v), 32'(x));
    end
    @(negedge clk); pad = '0; cyc(4);

    // R5 debounce on pin 1, threshold 3
    wr(pa(1, 1), 3); wr(pa(1, 0), 32'h21);
    @(negedge clk); pad[1] = 1'b1; cyc(5);
    rd(pa(1, 2), d); check("R5 no ticks", d, 0);
    pulse_tick(); pulse_tick(); cyc(2);
    rd(pa(1, 2), d); check("R5 two ticks", d, 0);
    @(negedge clk); pad[1] = 1'b0; cyc(4);
    @(negedge clk); pad[1] = 1'b1; cyc(4);
    pulse_tick(); pulse_tick(); cyc(2);
    rd(pa(1, 2), d); check("R5 restart after bounce", d, 0);
    pulse_tick(); cyc(2);
    rd(pa(1, 2), d); check("R5 third tick", d, 1);
    wr(pa(1, 1), 0);
    @(negedge clk); pad[1] = 1'b0; cyc(4);
    rd(pa(1, 2), d); check("R4 thr0 bypass", d, 0);
    wr(pa(1, 0), 0);

    // R6 R7 trigger sweep
    for (int p = 0; p < N; p++) begin
      for (int t = 0; t < 4; t++) begin
        for (int pl = 0; pl < 2; pl++) begin
          logic e0, e1, e2, e3, e4;
          e0 = (t == 1 && pl == 0);
          e1 = e0 | (t == 1 && pl == 1) | (t == 2 && pl == 1) | (t == 3);
          e2 = (t == 1 && pl == 1);
          e3 = e2 | (t == 1 && pl == 0) | (t == 2 && pl == 0) | (t == 3);
          e4 = e0;
          wr(pa(p, 0), 32'(1 | (t << 2) | (pl << 4) | (1 << 6)));
          cyc(6); wr(pa(p, 5), 1);
          rd(9'h104, d); check("R7 initial level", d, 32'(e0) << p);
          check("R10 irq", 32'(irq), 32'(e0));
          @(negedge clk); pad[p] = 1'b1; cyc(6);
          rd(9'h104, d); check("R6 rise", d, 32'(e1) << p);
          wr(pa(p, 5), 1);
          rd(9'h104, d); check("R7 clear while high", d, 32'(e2) << p);
          @(negedge clk); pad[p] = 1'b0; cyc(6);
          rd(9'h104, d); check("R6 fall", d, 32'(e3) << p);
          check("R10 irq", 32'(irq), 32'(e3));
          wr(pa(p, 5), 1);
          rd(9'h104, d); check("R7 clear while low", d, 32'(e4) << p);
          wr(pa(p, 0), 0); wr(pa(p, 5), 1);
        end
      end
    end

    // R8 arming gates
    for (int p = 0; p < N; p++) begin
      for (int g = 0; g < 3; g++) begin
        int cv;
        cv = (g == 0) ? ((3 << 2) | (1 << 6)) : (g == 1) ? (1 | (3 << 2)) : (1 | (1 << 6));
        wr(pa(p, 0), 32'(cv));
        @(negedge clk); pad[p] = 1'b1; cyc(5);
        @(negedge clk); pad[p] = 1'b0; cyc(5);
        rd(9'h104, d); check("R8 disarmed", d, 0);
        wr(pa(p, 0), 0);
      end
    end

    // R9 clear with bit0=0, then event and clear in same cycle
    wr(pa(2, 0), 32'h4D);
    @(negedge clk); pad[2] = 1'b1; cyc(5);
    wr(pa(2, 5), 32'hFFFF_FFFE);
    rd(9'h104, d); check("R9 clear bit0=0", d, 32'h4);
    wr(pa(2, 5), 1);
    rd(9'h104, d); check("R9 clear", d, 0);
    @(negedge clk); pad[2] = 1'b0;
    cyc(2);
    wr(pa(2, 5), 1);
    rd(9'h104, d); check("R9 event beats clear", d, 32'h4);
    wr(pa(2, 5), 1);
    @(negedge clk); pad[2] = 1'b1;
    cyc(3);
    wr(pa(2, 5), 1);
    rd(9'h104, d); check("R9 late clear", d, 0);
    check("R10 irq low", 32'(irq), 0);
    wr(pa(2, 0), 0);
    @(negedge clk); pad[2] = 1'b0; cyc(4);

    // R10 multi-pin status, read-only
    wr(pa(0, 0), 32'h4D); wr(pa(7, 0), 32'h4D);
    @(negedge clk); pad[0] = 1'b1; pad[7] = 1'b1; cyc(5);
    wr(9'h104, 0);
    rd(9'h104, d); check("R10 status bits", d, 32'h81);
    check("R10 irq", 32'(irq), 1);
    wr(pa(0, 5), 1); wr(pa(7, 5), 1);
    wr(pa(0, 0), 0); wr(pa(7, 0), 0);
    @(negedge clk); pad = '0; cyc(4);

    // R11 undefined offsets
    wr(pa(0, 0), 3); wr(pa(0, 3), 0); wr(pa(0, 4), 1);
    wr(9'h018, 32'hFFFF_FFFF); wr(9'h01C, 32'hFFFF_FFFF);
    wr(9'h0F8, 32'hFFFF_FFFF); wr(9'h100, 32'hFFFF_FFFF);
    wr(9'h108, 32'hFFFF_FFFF); wr(9'h1F0, 32'hFFFF_FFFF);
    wr(pa(0, 2), 32'hFFFF_FFFF);
    rd(9'h018, d); check("R11 read", d, 0);
    rd(9'h01C, d); check("R11 read", d, 0);
    rd(9'h0F8, d); check("R11 read", d, 0);
    rd(9'h100, d); check("R11 read", d, 0);
    rd(9'h108, d); check("R11 read", d, 0);
    rd(9'h1F0, d); check("R11 read", d, 0);
    rd(pa(0, 2), d); check("R11 input ro", d, 0);
    rd(pa(0, 0), d); check("R11 cfg kept", d, 3);
    check("R11 oe kept", 32'(poe), 1);
    check("R11 out kept", 32'(pout), 1);

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule